// File: doc/BRIEF.md
# E3 G.832 Nibble-Parallel Receive Output Formatter

This block is the last stage of the receive path of an E3 framer that uses the G.832 frame layout. Upstream logic has already decoded the line and found frame alignment. It presents one recovered byte at a time and can mark the byte that opens a frame. The block cuts each byte into two 4-bit nibbles, high half first, and hands them to the terminal equipment, one nibble for each pulse of a nibble clock enable. Alongside every nibble it raises a frame-start flag and an overhead flag.

Inside, a position counter walks the uneven 537-byte frame. The frame has nine rows: six rows of 60 byte columns followed by three rows of 59. From that position the block decides whether the current byte is overhead. A mode pin chooses between nibble-parallel output and serial operation. In serial mode each enable stands for one bit, the nibble bus rests at zero, and the two flags are produced per bit.

The upstream source must hold `byte_in` steady across every enable that belongs to the same byte: two enables in nibble mode, eight in serial mode.

Top module: `e3_nib_fmt`

## Requirements
- R1: A synchronous active-high reset clears `nib_out`, `frame_out` and `oh_out` to zero and puts the position at the first slot of the first byte of row 1. The first enable after reset, with no frame mark, therefore reports a frame start.
- R2: In nibble mode (`nib_mode`=1) the first enable of a byte outputs `byte_in[7:4]` and the second outputs `byte_in[3:0]`. The outputs are registered on the clock edge where `nib_en` is high and are visible one cycle after the input.
- R3: `frame_out` is 1 only for the first output slot of each frame.
- R4: `oh_out` is 1 for every slot of an overhead byte and 0 for every payload slot. The overhead bytes are bytes 1 and 2 of row 1 and byte 1 of rows 2 to 6, which gives 7 overhead bytes and 530 payload bytes. The frame-start byte is overhead.
- R5: A frame holds 537 bytes, laid out as 6 rows of 60 bytes and then 3 rows of 59 bytes. In nibble mode the next frame start therefore falls 1074 enables after the previous one.
- R6: `sof_in` high together with `nib_en` forces the current slot to be slot 1 of row 1, byte 1, whatever the counter held. The output shows a frame start and the high nibble of `byte_in`, and counting continues from there.
- R7: In serial mode (`nib_mode`=0) each enable is one bit slot and each byte takes 8 slots. `nib_out` stays 0, `frame_out` is high for one slot per 4296, and `oh_out` is high for 56 slots per frame.
- R8: While `nib_en` is low, `nib_out`, `frame_out`, `oh_out` and the position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_mode | input | 1 | 1 = nibble-parallel, 0 = serial |
| nib_en | input | 1 | Output slot enable (nibble or bit) |
| sof_in | input | 1 | Upstream frame-start mark for the byte on `byte_in` |
| byte_in | input | 8 | Recovered byte, bit 7 sent first |
| nib_out | output | 4 | Nibble to terminal equipment |
| frame_out | output | 1 | First slot of a frame |
| oh_out | output | 1 | Slot belongs to an overhead byte |

## Verification
The hardest conditions to reach from the ports are the row-length change between rows 6 and 7 and the wrap from the last 59-byte row back to the next frame start. Both lie more than a thousand slots after any frame mark. The bench reaches them by running whole frames with no realignment, starting straight from reset, in both modes. It checks every slot against a position model built from the byte index, so the start of the second frame proves the total length. A realignment in the middle of a byte pair is driven from the vector table to cover R6.

// File: rtl/e3_nib_pkg.sv
package e3_nib_pkg;
  localparam int E3_ROWS       = 9;
  localparam int E3_LONG_ROWS  = 6;
  localparam int E3_LONG_COLS  = 60;
  localparam int E3_SHORT_COLS = 59;
  localparam int E3_OH_ROWS    = 6;
  localparam int E3_LEAD_OH    = 2;
  localparam int E3_SER_SLOTS  = 8;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_NIBBLE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/e3_nib_pos.sv
module e3_nib_pos
  import e3_nib_pkg::*;
#(
  parameter int ROWS       = E3_ROWS,
  parameter int LONG_ROWS  = E3_LONG_ROWS,
  parameter int LONG_COLS  = E3_LONG_COLS,
  parameter int SHORT_COLS = E3_SHORT_COLS,
  parameter int SER_SLOTS  = E3_SER_SLOTS,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(LONG_COLS),
  localparam int SW = $clog2(SER_SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nib_en,
  input  logic          sof_in,
  input  logic          nib_mode,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic [SW-1:0] slot
);
  localparam logic [RW-1:0] LAST_ROW   = RW'(ROWS - 1);
  localparam logic [RW-1:0] SHORT_ROW0 = RW'(LONG_ROWS);
  localparam logic [CW-1:0] LONG_END   = CW'(LONG_COLS - 1);
  localparam logic [CW-1:0] SHORT_END  = CW'(SHORT_COLS - 1);
  localparam logic [SW-1:0] SER_END    = SW'(SER_SLOTS - 1);
  localparam logic [SW-1:0] NIB_END    = SW'(1);

  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [SW-1:0] slot_end;
  logic [CW-1:0] col_end;
  logic          byte_done, row_done;

  // A frame mark from upstream overrides the stored position for this slot.
  assign row  = sof_in ? '0 : row_q;
  assign col  = sof_in ? '0 : col_q;
  assign slot = sof_in ? '0 : slot_q;

  always_comb begin
    slot_end  = (nib_mode == MODE_NIBBLE) ? NIB_END : SER_END;
    col_end   = (row < SHORT_ROW0) ? LONG_END : SHORT_END;
    byte_done = (slot >= slot_end);
    row_done  = (col >= col_end);
    row_d = row;
    col_d = col;
    slot_d = slot + SW'(1);
    if (byte_done) begin
      slot_d = '0;
      col_d  = col + CW'(1);
      if (row_done) begin
        col_d = '0;
        row_d = (row >= LAST_ROW) ? '0 : row + RW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      slot_q <= '0;
    end else if (nib_en) begin
      row_q  <= row_d;
      col_q  <= col_d;
      slot_q <= slot_d;
    end
  end

  assert_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
    (row_q <= LAST_ROW) && (col_q <= LONG_END));
  assert_short_row_R5: assert property (@(posedge clk) disable iff (rst)
    (row_q >= SHORT_ROW0) |-> (col_q <= SHORT_END));
  assert_pos_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !nib_en |=> $stable({row_q, col_q, slot_q}));
endmodule

// File: rtl/e3_nib_ohmap.sv
module e3_nib_ohmap
  import e3_nib_pkg::*;
#(
  parameter int ROWS      = E3_ROWS,
  parameter int LONG_COLS = E3_LONG_COLS,
  parameter int OH_ROWS   = E3_OH_ROWS,
  parameter int LEAD_OH   = E3_LEAD_OH,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(LONG_COLS)
) (
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  output logic          is_oh,
  output logic          is_fas
);
  localparam logic [RW-1:0] OH_ROW_LIM = RW'(OH_ROWS);
  localparam logic [CW-1:0] LEAD_LIM   = CW'(LEAD_OH);

  always_comb begin
    is_fas = (row == '0) && (col == '0);
    if (row == '0)
      is_oh = (col < LEAD_LIM);
    else
      is_oh = (row < OH_ROW_LIM) && (col == '0);
  end
endmodule

// File: rtl/e3_nib_fmt.sv
module e3_nib_fmt
  import e3_nib_pkg::*;
#(
  parameter int ROWS       = E3_ROWS,
  parameter int LONG_ROWS  = E3_LONG_ROWS,
  parameter int LONG_COLS  = E3_LONG_COLS,
  parameter int SHORT_COLS = E3_SHORT_COLS,
  parameter int OH_ROWS    = E3_OH_ROWS,
  parameter int LEAD_OH    = E3_LEAD_OH,
  parameter int SER_SLOTS  = E3_SER_SLOTS,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(LONG_COLS),
  localparam int SW = $clog2(SER_SLOTS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       nib_mode,
  input  logic       nib_en,
  input  logic       sof_in,
  input  logic [7:0] byte_in,
  output logic [3:0] nib_out,
  output logic       frame_out,
  output logic       oh_out
);
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [SW-1:0] slot;
  logic          is_oh, is_fas;
  logic [3:0]    nib_d;

  e3_nib_pos #(
    .ROWS(ROWS), .LONG_ROWS(LONG_ROWS), .LONG_COLS(LONG_COLS),
    .SHORT_COLS(SHORT_COLS), .SER_SLOTS(SER_SLOTS)
  ) u_pos (
    .clk(clk), .rst(rst), .nib_en(nib_en), .sof_in(sof_in),
    .nib_mode(nib_mode), .row(row), .col(col), .slot(slot)
  );

  e3_nib_ohmap #(
    .ROWS(ROWS), .LONG_COLS(LONG_COLS), .OH_ROWS(OH_ROWS), .LEAD_OH(LEAD_OH)
  ) u_map (
    .row(row), .col(col), .is_oh(is_oh), .is_fas(is_fas)
  );

  always_comb begin
    if (nib_mode == MODE_NIBBLE)
      nib_d = (slot == '0) ? byte_in[7:4] : byte_in[3:0];
    else
      nib_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_out   <= '0;
      frame_out <= 1'b0;
      oh_out    <= 1'b0;
    end else if (nib_en) begin
      nib_out   <= nib_d;
      frame_out <= is_fas && (slot == '0);
      oh_out    <= is_oh;
    end
  end

  assert_fas_is_oh_R4: assert property (@(posedge clk) disable iff (rst)
    frame_out |-> oh_out);
  assert_realign_R6: assert property (@(posedge clk) disable iff (rst)
    (nib_en && sof_in) |=> (frame_out && oh_out));
  assert_serial_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (nib_en && !nib_mode) |=> (nib_out == 4'h0));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !nib_en |=> $stable({nib_out, frame_out, oh_out}));
endmodule

// File: tb/e3_nib_fmt_test.sv
`timescale 1ns/1ps
module e3_nib_fmt_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nib_mode = 1'b1;
  logic       nib_en = 1'b0;
  logic       sof_in = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [3:0] nib_out;
  logic       frame_out, oh_out;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  e3_nib_fmt uut (
    .clk(clk), .rst(rst), .nib_mode(nib_mode), .nib_en(nib_en),
    .sof_in(sof_in), .byte_in(byte_in), .nib_out(nib_out),
    .frame_out(frame_out), .oh_out(oh_out)
  );

  // {sof, byte, exp_nib, exp_frame, exp_oh}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 8'hF6, 4'hF, 1'b1, 1'b1},
    {1'b0, 8'hF6, 4'h6, 1'b0, 1'b1},
    {1'b0, 8'h28, 4'h2, 1'b0, 1'b1},
    {1'b0, 8'h28, 4'h8, 1'b0, 1'b1},
    {1'b0, 8'hA5, 4'hA, 1'b0, 1'b0},
    {1'b0, 8'hA5, 4'h5, 1'b0, 1'b0},
    {1'b1, 8'h3C, 4'h3, 1'b1, 1'b1},
    {1'b0, 8'h3C, 4'hC, 1'b0, 1'b1}
  };

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [7:0] d);
    @(negedge clk);
    nib_en = 1'b1; sof_in = s; byte_in = d;
    @(negedge clk);
    nib_en = 1'b0; sof_in = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; nib_mode = mode; nib_en = 1'b0; sof_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic bit oh_byte(input int b);
    return (b < 2) || (b < 6 * 60 && b % 60 == 0);
  endfunction

  function automatic logic [7:0] dat(input int b);
    return 8'((b * 37 + 11) & 255);
  endfunction

  initial begin
    #(10ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    int oh_cnt;
    int fr_cnt;
    // R1: reset state
    do_reset(1'b1);
    chk(nib_out == 4'h0, "R1 nib_out", nib_out, 0);
    chk(frame_out == 1'b0, "R1 frame_out", frame_out, 0);
    chk(oh_out == 1'b0, "R1 oh_out", oh_out, 0);

    // Vector table: nibble order (R2), realign mid-frame (R6)
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13:6]);
      chk(nib_out == VEC[i][5:2], "R2 vec nib", nib_out, VEC[i][5:2]);
      chk(frame_out == VEC[i][1], "R6 vec frame", frame_out, VEC[i][1]);
      chk(oh_out == VEC[i][0], "R4 vec oh", oh_out, VEC[i][0]);
      if (i == 0) begin
        // R8: hold while enable is low
        @(negedge clk);
        @(negedge clk);
        chk(nib_out == 4'hF, "R8 hold nib", nib_out, 4'hF);
        chk(frame_out == 1'b1, "R8 hold frame", frame_out, 1);
        chk(oh_out == 1'b1, "R8 hold oh", oh_out, 1);
      end
    end

    // Full nibble-mode frame from reset, no frame mark (R1, R2, R3, R4, R5)
    do_reset(1'b1);
    oh_cnt = 0; fr_cnt = 0;
    for (int k = 0; k <= 1074; k++) begin
      int b;
      logic [7:0] d;
      b = (k / 2) % 537;
      d = dat(b);
      step(1'b0, d);
      chk(nib_out == ((k % 2 == 0) ? d[7:4] : d[3:0]), "R2 frame nib", nib_out,
          (k % 2 == 0) ? d[7:4] : d[3:0]);
      chk(frame_out == (k % 1074 == 0), "R3 R5 frame_out", frame_out, (k % 1074 == 0));
      chk(oh_out == oh_byte(b), "R4 oh_out", oh_out, oh_byte(b));
      if (k < 1074) begin
        oh_cnt += int'(oh_out);
        fr_cnt += int'(frame_out);
      end
    end
    chk(oh_cnt == 14, "R4 oh nibble total", oh_cnt, 14);
    chk(fr_cnt == 1, "R3 frame pulses", fr_cnt, 1);

    // Serial mode frame (R7)
    do_reset(1'b0);
    oh_cnt = 0; fr_cnt = 0;
    for (int k = 0; k <= 4296; k++) begin
      int b;
      b = (k / 8) % 537;
      step(1'b0, dat(b));
      chk(nib_out == 4'h0, "R7 serial nib", nib_out, 0);
      chk(frame_out == (k % 4296 == 0), "R7 serial frame", frame_out, (k % 4296 == 0));
      chk(oh_out == oh_byte(b), "R7 serial oh", oh_out, oh_byte(b));
      if (k < 4296) begin
        oh_cnt += int'(oh_out);
        fr_cnt += int'(frame_out);
      end
    end
    chk(oh_cnt == 56, "R7 serial oh total", oh_cnt, 56);
    chk(fr_cnt == 1, "R7 serial frame total", fr_cnt, 1);

    // R6: realign in the middle of a byte pair in nibble mode
    do_reset(1'b1);
    step(1'b0, 8'h11);
    step(1'b0, 8'h11);
    step(1'b0, 8'h22);
    step(1'b1, 8'h9E);
    chk(nib_out == 4'h9, "R6 realign nib", nib_out, 9);
    chk(frame_out == 1'b1, "R6 realign frame", frame_out, 1);
    step(1'b0, 8'h9E);
    chk(nib_out == 4'hE, "R6 realign lower", nib_out, 4'hE);
    chk(frame_out == 1'b0, "R6 realign frame low", frame_out, 0);

    finish_run();
  end
endmodule